// File: doc/BRIEF.md
# Instruction Prefetch Queue with Shared Read Port

This block sits between a CPU's instruction decoder and a 16-bit memory bus that returns data in the same clock as the request. It keeps a small byte queue of upcoming code. Whenever the queue has room for a whole bus word, it reads the next aligned code word. It passes the bytes to the decoder one at a time, in program order, through a valid/ready handshake.

A jump request empties the queue and, in the same clock, puts the aligned word that holds the jump target on the bus. When the target is odd, only the upper byte of that word is kept. The execution unit shares the bus through a word-read port. A word at an even address takes one bus cycle. A word at an odd address takes two: the odd address is read first and supplies the low-order byte, then the next even address supplies the high-order byte. One code prefetch may fit in between the two halves.

Top module: `code_prefetch_q`

## Requirements
- R1: While reset is held, `dec_valid` and `rd_valid` are low and `rd_ready` is high.
- R2: In a cycle with `jump_req` high, `bus_strobe` is high, `bus_addr` is the target with bit 0 cleared, and `dec_valid` is low.
- R3: After a jump to an even target, the next byte handed to the decoder is the byte at the target address.
- R4: After a jump to an odd target, the first byte handed to the decoder is the byte at the target address. It comes from the upper data lane of the aligned word.
- R5: The queue holds 4 bytes. A code fetch is issued only when at least 2 bytes are free. Consecutive code fetches use even addresses 2 apart, starting 2 above the aligned target.
- R6: Bytes reach the decoder in strictly ascending address order, with no gaps and no repeats, whatever the decoder's ready pattern.
- R7: A word read at an even address uses one bus cycle at that address. `rd_valid` pulses in the next cycle with `rd_data` = {byte[a+1], byte[a]}. Bus lanes: `bus_rdata[7:0]` is the even byte and `bus_rdata[15:8]` is the odd byte.
- R8: A word read at an odd address a uses one bus cycle at a, taking the low result byte from `bus_rdata[15:8]`. A later bus cycle at a+1 takes the high result byte from `bus_rdata[7:0]`.
- R9: An accepted data read takes the bus ahead of a code fetch: the first bus cycle after acceptance goes to the read.
- R10: Between the two halves of an odd-address read, one code fetch is issued if the queue has room. The second half follows in the cycle after it.
- R11: A jump takes the bus even while a split read is in progress. The read then completes with correct data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jump_req | input | 1 | Flush queue and fetch at `jump_addr` this cycle |
| jump_addr | input | 24 | Jump target byte address |
| dec_byte | output | 8 | Head byte of the queue |
| dec_valid | output | 1 | `dec_byte` is valid |
| dec_ready | input | 1 | Decoder takes the head byte |
| rd_req | input | 1 | Data word read request |
| rd_addr | input | 24 | Data read byte address |
| rd_ready | output | 1 | Read port can accept a request |
| rd_data | output | 16 | Read result, high byte from address+1 |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` is valid |
| bus_strobe | output | 1 | Bus read cycle this clock |
| bus_addr | output | 24 | Bus byte address |
| bus_rdata | input | 16 | Bus data, returned in the strobe cycle |

## Verification
A jump and a pending data read can arrive in the same clock, and a flush can land in the middle of a split read. The bench accepts a read in the jump cycle itself. It also raises a jump between the two halves of an odd-address read. In each case it checks, cycle by cycle, the order of strobe addresses (target, read, gap prefetch, second half). It then confirms that the assembled read word and the first decoder byte after the jump both match the bench's address-derived memory pattern.

// File: rtl/code_prefetch_q.sv
module code_prefetch_q #(
  parameter int ADDR_W = 24,
  parameter int QDEPTH = 4,
  parameter logic [23:0] BOOT_PC = 24'h000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jump_req,
  input  logic [ADDR_W-1:0] jump_addr,
  output logic [7:0]        dec_byte,
  output logic              dec_valid,
  input  logic              dec_ready,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              bus_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_rdata
);
  localparam int CW = $clog2(QDEPTH + 1);

  typedef enum logic [1:0] {RS_IDLE, RS_LOW, RS_HIGH} rd_st_t;

  logic [7:0]        q [QDEPTH];
  logic [7:0]        q_n [QDEPTH];
  logic [CW-1:0]     cnt, cnt_n, base;
  logic [ADDR_W-1:0] fetch_pc, rd_a, jmp_al;
  logic [7:0]        rd_lo;
  rd_st_t            rs;
  logic              gap_used;
  logic              pop, pf_room, gap_pf, rd_bus, pf;

  assign jmp_al    = {jump_addr[ADDR_W-1:1], 1'b0};
  assign dec_byte  = q[0];
  assign dec_valid = (cnt != '0) && !jump_req;
  assign pop       = dec_valid && dec_ready;
  assign rd_ready  = (rs == RS_IDLE);
  assign pf_room   = (int'(cnt) <= QDEPTH - 2);
  assign gap_pf    = !jump_req && (rs == RS_HIGH) && !gap_used && pf_room;
  assign rd_bus    = !jump_req && ((rs == RS_LOW) || ((rs == RS_HIGH) && !gap_pf));
  assign pf        = !jump_req && (((rs == RS_IDLE) && pf_room) || gap_pf);
  assign bus_strobe = jump_req || rd_bus || pf;
  assign base      = cnt - CW'(pop);

  always_comb begin
    if (jump_req)             bus_addr = jmp_al;
    else if (rd_bus)          bus_addr = (rs == RS_LOW) ? rd_a : rd_a + ADDR_W'(1);
    else                      bus_addr = fetch_pc;
  end

  always_comb begin
    for (int i = 0; i < QDEPTH - 1; i++) q_n[i] = pop ? q[i+1] : q[i];
    q_n[QDEPTH-1] = q[QDEPTH-1];
    cnt_n = base;
    if (jump_req) begin
      q_n[0] = jump_addr[0] ? bus_rdata[15:8] : bus_rdata[7:0];
      q_n[1] = bus_rdata[15:8];
      cnt_n  = jump_addr[0] ? CW'(1) : CW'(2);
    end else if (pf) begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (CW'(i) == base)          q_n[i] = bus_rdata[7:0];
        if (CW'(i) == base + CW'(1)) q_n[i] = bus_rdata[15:8];
      end
      cnt_n = base + CW'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
      cnt      <= '0;
      fetch_pc <= ADDR_W'(BOOT_PC);
    end else begin
      q   <= q_n;
      cnt <= cnt_n;
      if (jump_req)  fetch_pc <= jmp_al + ADDR_W'(2);
      else if (pf)   fetch_pc <= fetch_pc + ADDR_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs       <= RS_IDLE;
      rd_a     <= '0;
      rd_lo    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      gap_used <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (rs)
        RS_IDLE: if (rd_req) begin
          rd_a <= rd_addr;
          rs   <= RS_LOW;
        end
        RS_LOW: if (rd_bus) begin
          if (rd_a[0]) begin
            rd_lo    <= bus_rdata[15:8];
            gap_used <= 1'b0;
            rs       <= RS_HIGH;
          end else begin
            rd_data  <= bus_rdata;
            rd_valid <= 1'b1;
            rs       <= RS_IDLE;
          end
        end
        RS_HIGH: begin
          if (gap_pf) gap_used <= 1'b1;
          if (rd_bus) begin
            rd_data  <= {bus_rdata[7:0], rd_lo};
            rd_valid <= 1'b1;
            rs       <= RS_IDLE;
          end
        end
        default: rs <= RS_IDLE;
      endcase
    end
  end

  p_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= QDEPTH);
  p_jump_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> bus_strobe && !dec_valid);
  p_jump_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |=> cnt == ($past(jump_addr[0]) ? CW'(1) : CW'(2)));
  p_rd_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ready |=> !rd_ready);
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_split_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rs == RS_HIGH) |-> $past(bus_addr[0]));
endmodule

// File: tb/code_prefetch_q_tb_top.sv
`timescale 1ns/1ps
module code_prefetch_q_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jump_req = 1'b0;
  logic [23:0] jump_addr = '0;
  logic [7:0]  dec_byte;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic        rd_req = 1'b0;
  logic [23:0] rd_addr = '0;
  logic        rd_ready;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        bus_strobe;
  logic [23:0] bus_addr;
  logic [15:0] bus_rdata;
  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
  endfunction

  assign bus_rdata = {mb(bus_addr | 24'h1), mb(bus_addr & 24'hFFFFFE)};

  code_prefetch_q dut_i (
    .clk(clk), .rst_n(rst_n), .jump_req(jump_req), .jump_addr(jump_addr),
    .dec_byte(dec_byte), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .bus_strobe(bus_strobe), .bus_addr(bus_addr), .bus_rdata(bus_rdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic exp_bus(input bit s, input logic [23:0] a, input string req);
    check(bus_strobe === s && (!s || bus_addr === a), req, {bus_strobe, 7'b0, bus_addr}, {s, 7'b0, a});
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic preload(input logic [23:0] t);
    nx(); jump_req = 1'b1; jump_addr = t; dec_ready = 1'b0;
    nx(); jump_req = 1'b0;
    repeat (3) nx();
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [23:0] t, exp_pc, exp_b, a;
    int got, n;
    repeat (3) nx();
    #1;
    check(!dec_valid && !rd_valid && rd_ready, "R1", {dec_valid, rd_valid, rd_ready}, 3'b001);
    nx(); rst_n = 1'b1;
    repeat (4) nx();

    // R3 R4 R5 R6: jump/stream sweep over offsets and ready patterns
    for (int b = 0; b < 2; b++) begin
      for (int off = 0; off < 8; off++) begin
        for (int pat = 0; pat < 3; pat++) begin
          t = (b == 0 ? 24'hFC058 : 24'h00FFF8) + 24'(off);
          nx(); jump_req = 1'b1; jump_addr = t; dec_ready = 1'b1;
          #1;
          check(bus_strobe && bus_addr == (t & 24'hFFFFFE) && !dec_valid, "R2",
                {dec_valid, bus_strobe, 6'b0, bus_addr}, {2'b01, 6'b0, t & 24'hFFFFFE});
          exp_pc = (t & 24'hFFFFFE) + 24'd2; exp_b = t; got = 0;
          for (int k = 0; k < 40; k++) begin
            nx(); jump_req = 1'b0;
            dec_ready = (pat == 0) ? 1'b1 : (k % (pat + 1) == 0);
            #1;
            if (bus_strobe) begin
              exp_bus(1'b1, exp_pc, "R5");
              exp_pc = exp_pc + 24'd2;
            end
            if (dec_valid && dec_ready) begin
              check(dec_byte == mb(exp_b), got == 0 ? (t[0] ? "R4" : "R3") : "R6",
                    {24'b0, dec_byte}, {24'b0, mb(exp_b)});
              exp_b++; got++;
            end
          end
          check(got >= 10, "R6", got, 10);
          dec_ready = 1'b0;
        end
      end
    end

    // R5: fill stops at capacity; drain count before refetch
    for (int o = 0; o < 2; o++) begin
      t = 24'hFC062 + 24'(o);
      nx(); jump_req = 1'b1; jump_addr = t; dec_ready = 1'b0;
      #1; n = int'(bus_strobe);
      for (int k = 1; k < 10; k++) begin
        nx(); jump_req = 1'b0; #1; n += int'(bus_strobe);
      end
      check(n == 2, "R5", n, 2);
      got = 0; exp_b = t;
      for (int k = 0; k < 6; k++) begin
        nx(); dec_ready = 1'b1; #1;
        if (bus_strobe) break;
        if (dec_valid) begin
          check(dec_byte == mb(exp_b), "R6", dec_byte, mb(exp_b));
          exp_b++; got++;
        end
      end
      check(got == (o == 0 ? 2 : 1), "R5", got, (o == 0 ? 2 : 1));
      dec_ready = 1'b0;
    end

    // R7 R8 R9: reads with a full queue
    for (int i = 0; i < 8; i++) begin
      a = 24'h004000 + 24'(i);
      preload(24'hFC05E);
      rd_req = 1'b1; rd_addr = a;
      nx(); rd_req = 1'b0; #1;
      exp_bus(1'b1, a, a[0] ? "R8" : "R9");
      if (a[0]) begin
        nx(); #1; exp_bus(1'b1, a + 24'd1, "R8");
      end
      nx(); #1;
      check(rd_valid && rd_data == {mb(a + 24'd1), mb(a)}, a[0] ? "R8" : "R7",
            {15'b0, rd_valid, rd_data}, {15'b0, 1'b1, mb(a + 24'd1), mb(a)});
      exp_bus(1'b0, '0, "R5");
    end

    // R9 R10: read accepted in the jump cycle
    for (int i = 0; i < 8; i++) begin
      a = 24'h004000 + 24'(i);
      t = 24'hFC068;
      nx(); jump_req = 1'b1; jump_addr = t; rd_req = 1'b1; rd_addr = a; dec_ready = 1'b0;
      nx(); jump_req = 1'b0; rd_req = 1'b0; #1;
      exp_bus(1'b1, a, "R9");
      nx(); #1;
      exp_bus(1'b1, t + 24'd2, a[0] ? "R10" : "R9");
      if (a[0]) begin
        nx(); #1; exp_bus(1'b1, a + 24'd1, "R10");
        nx(); #1;
      end
      if (!a[0]) check(rd_valid && rd_data == {mb(a + 24'd1), mb(a)}, "R7",
                       {15'b0, rd_valid, rd_data}, {15'b0, 1'b1, mb(a + 24'd1), mb(a)});
      else begin
        check(rd_valid && rd_data == {mb(a + 24'd1), mb(a)}, "R10",
              {15'b0, rd_valid, rd_data}, {15'b0, 1'b1, mb(a + 24'd1), mb(a)});
        exp_bus(1'b0, '0, "R5");
      end
      if (!a[0]) begin
        nx(); #1; exp_bus(1'b0, '0, "R5");
      end
    end

    // R11: jump between halves of a split read
    for (int i = 0; i < 4; i++) begin
      for (int o = 0; o < 2; o++) begin
        a = 24'h004001 + 24'(2 * i);
        t = 24'hFC072 + 24'(o);
        preload(24'hFC05E);
        rd_req = 1'b1; rd_addr = a;
        nx(); rd_req = 1'b0; #1; exp_bus(1'b1, a, "R8");
        nx(); jump_req = 1'b1; jump_addr = t; #1; exp_bus(1'b1, t & 24'hFFFFFE, "R11");
        nx(); jump_req = 1'b0; #1; exp_bus(1'b1, (t & 24'hFFFFFE) + 24'd2, "R10");
        nx(); #1; exp_bus(1'b1, a + 24'd1, "R11");
        nx(); #1;
        check(rd_valid && rd_data == {mb(a + 24'd1), mb(a)}, "R11",
              {15'b0, rd_valid, rd_data}, {15'b0, 1'b1, mb(a + 24'd1), mb(a)});
        exp_bus(1'b0, '0, "R5");
        nx(); dec_ready = 1'b1; #1;
        check(dec_valid && dec_byte == mb(t), o ? "R4" : "R3", {dec_valid, dec_byte}, {1'b1, mb(t)});
        nx(); dec_ready = 1'b0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule